// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block sits beside the decode stage of a five-stage in-order integer pipeline. The stages, in order, are fetch, decode/register-read, execute, buffer/data and write-back. Every source register that decode reads is compared with the destinations of the instructions now in execute, buffer/data and write-back. For each operand the block then returns either the register-file word, one of three in-flight results, or the program-counter value when the source is register 15.

The block keeps its own copy of the destination number, write-enable and load flag for each later stage. Decode hands these over on every clock. A load's data exists only at the end of buffer/data. An instruction that uses the loaded register in the very next slot therefore gets a one-cycle stall. During that stall the block puts a bubble, with its write-enable cleared, into its execute slot. The surrounding pipeline is expected to hold its fetch and decode registers while `stall` is high. Every other dependency is covered by bypassing, with no stall.

Top module: `operand_bypass_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, `stall` and `bubble_in_ex` are low. Every operand whose source is not register 15 selects the register file (select code 0).
- R2: A source that matches the destination of a non-load instruction one slot ahead (now in execute, write-enable high) gets select code 1, and its data equals `ex_result`.
- R3: A source that matches the destination of an instruction two slots ahead (now in buffer/data, write-enable high, load or not) gets select code 2, and its data equals `mem_result`.
- R4: A source that matches the destination of an instruction three slots ahead (now in write-back, write-enable high) gets select code 3, and its data equals `wb_result`.
- R5: When more than one stage matches the same source, the youngest producer wins. Execute beats buffer/data, and buffer/data beats write-back.
- R6: An instruction whose write-enable was low never supplies a forwarded operand. A matching source still gets select code 0.
- R7: Source register 15 always gets select code 4, with data equal to `id_pc + 8`. A write to register 15 is never forwarded and never causes a stall.
- R8: `stall` is high exactly when a source flagged as used matches the destination of a load, with write-enable high, that is now in execute. A matching source flagged as unused causes no stall. Each such stall lasts exactly one cycle while decode holds its instruction.
- R9: In the cycle after a stall, `bubble_in_ex` is high and no operand selects execute. The held instruction then takes the loaded value through the buffer/data path (code 2).
- R10: A stall on one source and forwarding on another source can occur in the same cycle, and each is reported correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_src | input | NSRC*AW | Source register numbers in decode, source i in bits [i*AW +: AW] |
| id_src_used | input | NSRC | Per-source flag: the instruction really reads this source |
| id_dst | input | AW | Destination register of the decode instruction |
| id_we | input | 1 | Decode instruction writes its destination |
| id_load | input | 1 | Decode instruction is a load |
| rf_rdata | input | NSRC*DW | Register-file read data per source |
| id_pc | input | DW | Program counter of the decode instruction |
| ex_result | input | DW | ALU result of the instruction in execute |
| mem_result | input | DW | Buffer/data output: held ALU result or load data |
| wb_result | input | DW | Value being written back |
| opnd_sel | output | NSRC*3 | Per-source select: 0 reg file, 1 execute, 2 buffer/data, 3 write-back, 4 PC+8 |
| opnd_data | output | NSRC*DW | Per-source selected operand |
| stall | output | 1 | Hold fetch and decode this cycle; a bubble enters execute |
| bubble_in_ex | output | 1 | Execute holds an injected bubble |

## Verification
The load-use stall and normal bypassing can fall in the same cycle. An ALU write to one register, then a load to another, then an instruction that reads both gives exactly this. In the stall cycle the bench expects `stall` high, with the second operand already taken from buffer/data. In the cycle after, with decode held, it expects the loaded operand from buffer/data and the ALU operand from write-back. The bench also issues three writers to one register, and a disabled writer, to judge priority and the write-enable qualification.

// File: rtl/operand_bypass_ctl.sv
module operand_bypass_ctl #(
  parameter int AW        = 4,
  parameter int DW        = 32,
  parameter int NSRC      = 2,
  parameter int PC_IDX    = 15,
  parameter int PC_AHEAD  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC*AW-1:0]   id_src,
  input  logic [NSRC-1:0]      id_src_used,
  input  logic [AW-1:0]        id_dst,
  input  logic                 id_we,
  input  logic                 id_load,
  input  logic [NSRC*DW-1:0]   rf_rdata,
  input  logic [DW-1:0]        id_pc,
  input  logic [DW-1:0]        ex_result,
  input  logic [DW-1:0]        mem_result,
  input  logic [DW-1:0]        wb_result,
  output logic [NSRC*3-1:0]    opnd_sel,
  output logic [NSRC*DW-1:0]   opnd_data,
  output logic                 stall,
  output logic                 bubble_in_ex
);

  localparam logic [2:0] SEL_RF  = 3'd0;
  localparam logic [2:0] SEL_EX  = 3'd1;
  localparam logic [2:0] SEL_MEM = 3'd2;
  localparam logic [2:0] SEL_WB  = 3'd3;
  localparam logic [2:0] SEL_PC  = 3'd4;
  localparam logic [AW-1:0] PC_REG = AW'(PC_IDX);

  logic [AW-1:0] ex_dst, mem_dst, wb_dst;
  logic          ex_we, mem_we, wb_we, ex_ld;
  logic [NSRC-1:0] use_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_dst <= '0; mem_dst <= '0; wb_dst <= '0;
      ex_we  <= 1'b0; mem_we <= 1'b0; wb_we <= 1'b0;
      ex_ld  <= 1'b0;
      bubble_in_ex <= 1'b0;
    end else begin
      ex_dst  <= id_dst;
      ex_we   <= id_we & ~stall;
      ex_ld   <= id_load & ~stall;
      mem_dst <= ex_dst;
      mem_we  <= ex_we;
      wb_dst  <= mem_dst;
      wb_we   <= mem_we;
      bubble_in_ex <= stall;
    end
  end

  assign stall = |use_hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [AW-1:0] s;
    logic          is_pc, hit_ex, hit_mem, hit_wb;
    logic [2:0]    sel;

    assign s       = id_src[i*AW +: AW];
    assign is_pc   = (s == PC_REG);
    assign hit_ex  = ex_we  & ~ex_ld & (ex_dst  == s);
    assign hit_mem = mem_we & (mem_dst == s);
    assign hit_wb  = wb_we  & (wb_dst  == s);
    assign use_hit[i] = id_src_used[i] & ~is_pc & ex_we & ex_ld & (ex_dst == s);

    always_comb begin
      if (is_pc)        sel = SEL_PC;
      else if (hit_ex)  sel = SEL_EX;
      else if (hit_mem) sel = SEL_MEM;
      else if (hit_wb)  sel = SEL_WB;
      else              sel = SEL_RF;
    end

    assign opnd_sel[i*3 +: 3] = sel;

    always_comb begin
      case (sel)
        SEL_EX:  opnd_data[i*DW +: DW] = ex_result;
        SEL_MEM: opnd_data[i*DW +: DW] = mem_result;
        SEL_WB:  opnd_data[i*DW +: DW] = wb_result;
        SEL_PC:  opnd_data[i*DW +: DW] = id_pc + DW'(PC_AHEAD);
        default: opnd_data[i*DW +: DW] = rf_rdata[i*DW +: DW];
      endcase
    end

    // R7
    pc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_src[i*AW +: AW] == PC_REG) |->
        (opnd_data[i*DW +: DW] == id_pc + DW'(PC_AHEAD)));

    // R9
    no_ex_after_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_in_ex |-> (opnd_sel[i*3 +: 3] != SEL_EX));
  end

  // R8
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R8
  stall_needs_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (id_src_used != '0));

  // R9
  bubble_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> bubble_in_ex);

  // R9
  bubble_only_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> !bubble_in_ex);

endmodule

// File: tb/operand_bypass_ctl_tb.sv
module operand_bypass_ctl_tb;
  localparam int AW = 4, DW = 32, NSRC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC*AW-1:0] id_src = '0;
  logic [NSRC-1:0]    id_src_used = '0;
  logic [AW-1:0]      id_dst = '0;
  logic               id_we = 1'b0, id_load = 1'b0;
  logic [NSRC*DW-1:0] rf_rdata = {32'hAAAA_0011, 32'hAAAA_0010};
  logic [DW-1:0]      id_pc = 32'h0000_0100;
  logic [DW-1:0]      ex_result = 32'hE0E0_0001;
  logic [DW-1:0]      mem_result = 32'hD0D0_0002;
  logic [DW-1:0]      wb_result = 32'hB0B0_0003;
  logic [NSRC*3-1:0]  opnd_sel;
  logic [NSRC*DW-1:0] opnd_data;
  logic               stall, bubble_in_ex;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  operand_bypass_ctl #(.AW(AW), .DW(DW), .NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .id_src(id_src), .id_src_used(id_src_used),
    .id_dst(id_dst), .id_we(id_we), .id_load(id_load), .rf_rdata(rf_rdata),
    .id_pc(id_pc), .ex_result(ex_result), .mem_result(mem_result),
    .wb_result(wb_result), .opnd_sel(opnd_sel), .opnd_data(opnd_data),
    .stall(stall), .bubble_in_ex(bubble_in_ex));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic dec(input int dst, input bit we, input bit ld,
                     input int s0, input bit u0, input int s1, input bit u1);
    id_dst = AW'(dst); id_we = we; id_load = ld;
    id_src = {AW'(s1), AW'(s0)}; id_src_used = {u1, u0};
    #1;
  endtask

  task automatic adv;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic nop; dec(0, 0, 0, 0, 0, 0, 0); endtask

  task automatic flush;
    for (int k = 0; k < 3; k++) begin nop(); adv(); end
  endtask

  task automatic t_reset;
    nop();
    chk("R1 stall in reset", 32'(stall), 0);
    chk("R1 sel0 in reset", 32'(opnd_sel[2:0]), 0);
    adv(); rst_n = 1'b1; adv(); #1;
    chk("R1 stall after reset", 32'(stall), 0);
    chk("R1 bubble after reset", 32'(bubble_in_ex), 0);
    chk("R1 sel1 after reset", 32'(opnd_sel[5:3]), 0);
    chk("R1 data0 after reset", opnd_data[31:0], 32'hAAAA_0010);
  endtask

  task automatic t_ex_fwd;
    flush();
    dec(3, 1, 0, 0, 0, 0, 0); adv();
    dec(0, 0, 0, 3, 1, 4, 1);
    chk("R2 sel0 execute", 32'(opnd_sel[2:0]), 1);
    chk("R2 data0 execute", opnd_data[31:0], ex_result);
    chk("R2 sel1 unrelated reg file", 32'(opnd_sel[5:3]), 0);
    chk("R2 data1 reg file", opnd_data[63:32], 32'hAAAA_0011);
  endtask

  task automatic t_mem_wb_fwd;
    flush();
    dec(5, 1, 0, 0, 0, 0, 0); adv(); nop(); adv();
    dec(0, 0, 0, 1, 1, 5, 1);
    chk("R3 sel1 buffer", 32'(opnd_sel[5:3]), 2);
    chk("R3 data1 buffer", opnd_data[63:32], mem_result);
    flush();
    dec(6, 1, 0, 0, 0, 0, 0); adv(); nop(); adv(); nop(); adv();
    dec(0, 0, 0, 6, 1, 0, 0);
    chk("R4 sel0 writeback", 32'(opnd_sel[2:0]), 3);
    chk("R4 data0 writeback", opnd_data[31:0], wb_result);
  endtask

  task automatic t_priority;
    flush();
    dec(7, 1, 0, 0, 0, 0, 0); adv();
    dec(7, 1, 0, 0, 0, 0, 0); adv();
    dec(7, 1, 0, 0, 0, 0, 0); adv();
    dec(0, 0, 0, 7, 1, 0, 0);
    chk("R5 three matches pick execute", 32'(opnd_sel[2:0]), 1);
    flush();
    dec(7, 1, 0, 0, 0, 0, 0); adv();
    dec(7, 1, 0, 0, 0, 0, 0); adv();
    nop(); adv();
    dec(0, 0, 0, 0, 0, 7, 1);
    chk("R5 buffer beats writeback", 32'(opnd_sel[5:3]), 2);
  endtask

  task automatic t_no_we;
    flush();
    dec(8, 0, 0, 0, 0, 0, 0); adv();
    dec(0, 0, 0, 8, 1, 0, 0);
    chk("R6 disabled writer ignored", 32'(opnd_sel[2:0]), 0);
    chk("R6 data from reg file", opnd_data[31:0], 32'hAAAA_0010);
    dec(8, 0, 1, 0, 0, 0, 0); adv();
    dec(0, 0, 0, 8, 1, 0, 0);
    chk("R6 disabled load no stall", 32'(stall), 0);
  endtask

  task automatic t_pc;
    flush();
    dec(15, 1, 1, 0, 0, 0, 0); adv();
    dec(0, 0, 0, 15, 1, 15, 1);
    chk("R7 no stall on r15 load", 32'(stall), 0);
    chk("R7 sel0 pc", 32'(opnd_sel[2:0]), 4);
    chk("R7 data0 pc+8", opnd_data[31:0], 32'h0000_0108);
    chk("R7 data1 pc+8", opnd_data[63:32], 32'h0000_0108);
  endtask

  task automatic t_load_use;
    flush();
    dec(9, 1, 1, 0, 0, 0, 0); adv();
    dec(0, 0, 0, 9, 1, 4, 1);
    chk("R8 stall on load use", 32'(stall), 1);
    chk("R8 no bubble yet", 32'(bubble_in_ex), 0);
    adv(); #1;
    chk("R8 stall lasts one cycle", 32'(stall), 0);
    chk("R9 bubble in execute", 32'(bubble_in_ex), 1);
    chk("R9 load value via buffer", 32'(opnd_sel[2:0]), 2);
    chk("R9 load data", opnd_data[31:0], mem_result);
    adv(); nop();
    chk("R9 bubble gone", 32'(bubble_in_ex), 0);
    flush();
    dec(10, 1, 1, 0, 0, 0, 0); adv(); nop(); adv();
    dec(0, 0, 0, 10, 1, 0, 0);
    chk("R3 load one gap no stall", 32'(stall), 0);
    chk("R3 load one gap via buffer", 32'(opnd_sel[2:0]), 2);
    flush();
    dec(11, 1, 1, 0, 0, 0, 0); adv();
    dec(0, 0, 0, 11, 0, 12, 1);
    chk("R8 unused source no stall", 32'(stall), 0);
  endtask

  task automatic t_stall_and_fwd;
    flush();
    dec(2, 1, 0, 0, 0, 0, 0); adv();
    dec(9, 1, 1, 0, 0, 0, 0); adv();
    dec(5, 1, 0, 9, 1, 2, 1);
    chk("R10 stall", 32'(stall), 1);
    chk("R10 sel1 buffer during stall", 32'(opnd_sel[5:3]), 2);
    adv(); #1;
    chk("R10 stall released", 32'(stall), 0);
    chk("R10 sel0 load via buffer", 32'(opnd_sel[2:0]), 2);
    chk("R10 sel1 writeback", 32'(opnd_sel[5:3]), 3);
    chk("R10 data1", opnd_data[63:32], wb_result);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ex_fwd();
    t_mem_wb_fwd();
    t_priority();
    t_no_we();
    t_pc();
    t_load_use();
    t_stall_and_fwd();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule